// File: doc/BRIEF.md
# Color Bar Test Pattern Generator

This block sits in a video pixel path and, when a diagnostic mode is selected, replaces the live picture with eight vertical full-saturation bars of equal width. With the pattern off, the incoming pixel is forwarded unchanged. In both cases there is one cycle of delay, and the active-video and start-of-line strobes are delayed by the same cycle so that they stay aligned with the data. The same bars can be produced as full-swing RGB or as studio-range YCbCr.

Each line begins with a start-of-line strobe. On that strobe the block samples the 2-bit mode field, the format select and the active line width. These values then hold for the whole line, so a change made in the middle of a line never shows up as a partly drawn pattern. A position tracker counts active pixels and turns the count into a bar number. The bar width is the line width divided by eight. Any pixels left over from that division go to the final bar.

Top module: `cbar_gen`

## Requirements
- R1: The pattern is drawn only when the mode field latched at the last start-of-line equals 2'b01. For the values 00, 10 and 11, out_c0/out_c1/out_c2 equal in_c0/in_c1/in_c2 from the previous cycle.
- R2: mode_sel, fmt_ycc and line_width are sampled only in a cycle where sol_in is high, and they take effect from that same cycle. Changing them in the middle of a line has no effect on that line.
- R3: Bars run left to right as index 0..7: white, yellow, cyan, green, magenta, red, blue, black. The bar index never decreases within a line.
- R4: With fmt_ycc=0 the outputs are c0=R, c1=G, c2=B. Each component is 0 or 255: white 255/255/255, yellow 255/255/0, cyan 0/255/255, green 0/255/0, magenta 255/0/255, red 255/0/0, blue 0/0/255, black 0/0/0.
- R5: With fmt_ycc=1 the outputs are c0=Y, c1=Cb, c2=Cr: white 235/128/128, yellow 210/16/146, cyan 170/166/16, green 145/54/34, magenta 106/202/222, red 81/90/240, blue 41/240/110, black 16/128/128.
- R6: The bar width is bw = line_width/8, rounded down. Active pixel k of a line (counted from 0) lies in bar min(k/bw, 7), so the remainder pixels extend bar 7. When bw is 0, the whole line stays in bar 0.
- R7: The pixel count is cleared by sol_in and advances only in cycles where vid_act_in is high. A pixel in the same cycle as sol_in is pixel 0.
- R8: Outputs are registered. vid_act_out and sol_out equal vid_act_in and sol_in from one cycle earlier.
- R9: While the pattern is on and vid_act_in is low, the outputs show black in the latched format.
- R10: rst is synchronous and active high. A cycle with rst high makes the next outputs black in the format given by fmt_ycc (RGB 0/0/0, YCbCr 16/128/128), with both strobes low. It also clears the pixel count and turns the pattern off until the next start-of-line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_sel | input | 2 | Diagnostic mode field; 01 selects bars |
| fmt_ycc | input | 1 | 0 = RGB, 1 = YCbCr output |
| line_width | input | WIDTH_W | Active pixels per line |
| vid_act_in | input | 1 | Active-video qualifier |
| sol_in | input | 1 | Start-of-line strobe |
| in_c0 | input | 8 | Live component 0 |
| in_c1 | input | 8 | Live component 1 |
| in_c2 | input | 8 | Live component 2 |
| vid_act_out | output | 1 | Delayed active-video |
| sol_out | output | 1 | Delayed start-of-line |
| out_c0 | output | 8 | Component 0 (R or Y) |
| out_c1 | output | 8 | Component 1 (G or Cb) |
| out_c2 | output | 8 | Component 2 (B or Cr) |

## Verification
The assertions check the following on every cycle: the strobe delay, pass-through whenever the pattern is off, the output state after reset, black output during blanking, the legal component levels in each format, and that the bar index never moves backwards within a line. They cannot show which colour lands on which pixel. The bench scenarios cover that: exact per-bar values in both formats, bar edges for a line width that divides by eight and for one that does not, gaps in active video, and changes to the settings in the middle of a line being ignored.

// File: rtl/cbar_pkg.sv
package cbar_pkg;

  localparam logic [1:0] MODE_BARS = 2'b01;

  typedef struct packed {
    logic [7:0] c0;
    logic [7:0] c1;
    logic [7:0] c2;
  } pix_t;

  // Black in the requested format
  function automatic pix_t black_pix(input logic ycc);
    pix_t p;
    p = ycc ? '{c0: 8'd16, c1: 8'd128, c2: 8'd128} : '{c0: 8'd0, c1: 8'd0, c2: 8'd0};
    return p;
  endfunction

  // Bar colour: RGB follows from the index bits, YCbCr from a short table
  function automatic pix_t bar_pix(input logic [2:0] idx, input logic ycc);
    pix_t p;
    if (!ycc) begin
      p.c0 = {8{~idx[1]}};
      p.c1 = {8{~idx[2]}};
      p.c2 = {8{~idx[0]}};
    end else begin
      unique case (idx)
        3'd0:    p = '{c0: 8'd235, c1: 8'd128, c2: 8'd128};
        3'd1:    p = '{c0: 8'd210, c1: 8'd16,  c2: 8'd146};
        3'd2:    p = '{c0: 8'd170, c1: 8'd166, c2: 8'd16};
        3'd3:    p = '{c0: 8'd145, c1: 8'd54,  c2: 8'd34};
        3'd4:    p = '{c0: 8'd106, c1: 8'd202, c2: 8'd222};
        3'd5:    p = '{c0: 8'd81,  c1: 8'd90,  c2: 8'd240};
        3'd6:    p = '{c0: 8'd41,  c1: 8'd240, c2: 8'd110};
        default: p = '{c0: 8'd16,  c1: 8'd128, c2: 8'd128};
      endcase
    end
    return p;
  endfunction

endpackage

// File: rtl/cbar_cfg_latch.sv
module cbar_cfg_latch (
  input  logic       clk,
  input  logic       rst,
  input  logic       sol_in,
  input  logic [1:0] mode_sel,
  input  logic       fmt_ycc,
  output logic       pat_en_eff,
  output logic       fmt_eff,
  output logic       pat_en_q,
  output logic       fmt_q
);
  import cbar_pkg::*;

  // Settings are live in the strobe cycle itself, then held for the line
  assign pat_en_eff = sol_in ? (mode_sel == MODE_BARS) : pat_en_q;
  assign fmt_eff    = sol_in ? fmt_ycc : fmt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      pat_en_q <= 1'b0;
      fmt_q    <= 1'b0;
    end else begin
      pat_en_q <= pat_en_eff;
      fmt_q    <= fmt_eff;
    end
  end
endmodule

// File: rtl/cbar_bar_track.sv
module cbar_bar_track #(
  parameter int WIDTH_W = 12
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               sol_in,
  input  logic               vid_act_in,
  input  logic [WIDTH_W-1:0] line_width,
  output logic [2:0]         bar_eff,
  output logic [2:0]         bar_q
);
  localparam int BW_W = WIDTH_W - 3;
  localparam logic [2:0] LAST_BAR = 3'd7;

  logic [BW_W-1:0] bw_q, bw_eff;
  logic [BW_W-1:0] pos_q, pos_eff;
  logic            at_edge;

  assign bw_eff  = sol_in ? line_width[WIDTH_W-1:3] : bw_q;
  assign pos_eff = sol_in ? '0 : pos_q;
  assign bar_eff = sol_in ? 3'd0 : bar_q;
  assign at_edge = (bw_eff != '0) && (pos_eff == bw_eff - 1'b1);

  always_ff @(posedge clk) begin
    if (rst) begin
      bw_q  <= '0;
      pos_q <= '0;
      bar_q <= 3'd0;
    end else begin
      bw_q  <= bw_eff;
      pos_q <= pos_eff;
      bar_q <= bar_eff;
      if (vid_act_in && bar_eff != LAST_BAR && bw_eff != '0) begin
        if (at_edge) begin
          bar_q <= bar_eff + 3'd1;
          pos_q <= '0;
        end else begin
          pos_q <= pos_eff + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/cbar_gen.sv
module cbar_gen #(
  parameter int WIDTH_W = 12
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [1:0]         mode_sel,
  input  logic               fmt_ycc,
  input  logic [WIDTH_W-1:0] line_width,
  input  logic               vid_act_in,
  input  logic               sol_in,
  input  logic [7:0]         in_c0,
  input  logic [7:0]         in_c1,
  input  logic [7:0]         in_c2,
  output logic               vid_act_out,
  output logic               sol_out,
  output logic [7:0]         out_c0,
  output logic [7:0]         out_c1,
  output logic [7:0]         out_c2
);
  import cbar_pkg::*;

  logic       pat_en_eff, fmt_eff, pat_en_q, fmt_q;
  logic [2:0] bar_eff, bar_reg;
  pix_t       pix_d, out_q;

  cbar_cfg_latch u_cfg (
    .clk(clk), .rst(rst), .sol_in(sol_in), .mode_sel(mode_sel), .fmt_ycc(fmt_ycc),
    .pat_en_eff(pat_en_eff), .fmt_eff(fmt_eff), .pat_en_q(pat_en_q), .fmt_q(fmt_q)
  );

  cbar_bar_track #(.WIDTH_W(WIDTH_W)) u_track (
    .clk(clk), .rst(rst), .sol_in(sol_in), .vid_act_in(vid_act_in),
    .line_width(line_width), .bar_eff(bar_eff), .bar_q(bar_reg)
  );

  always_comb begin
    if (!pat_en_eff)     pix_d = '{c0: in_c0, c1: in_c1, c2: in_c2};
    else if (vid_act_in) pix_d = bar_pix(bar_eff, fmt_eff);
    else                 pix_d = black_pix(fmt_eff);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_q       <= black_pix(fmt_ycc);
      vid_act_out <= 1'b0;
      sol_out     <= 1'b0;
    end else begin
      out_q       <= pix_d;
      vid_act_out <= vid_act_in;
      sol_out     <= sol_in;
    end
  end

  assign out_c0 = out_q.c0;
  assign out_c1 = out_q.c1;
  assign out_c2 = out_q.c2;
endmodule

// File: rtl/cbar_gen_chk.sv
module cbar_gen_chk (
  input logic       clk,
  input logic       rst,
  input logic [1:0] mode_sel,
  input logic       fmt_ycc,
  input logic       vid_act_in,
  input logic       sol_in,
  input logic [7:0] in_c0,
  input logic [7:0] in_c1,
  input logic [7:0] in_c2,
  input logic       vid_act_out,
  input logic       sol_out,
  input logic [7:0] out_c0,
  input logic [7:0] out_c1,
  input logic [7:0] out_c2,
  input logic       pat_en_q,
  input logic       fmt_q,
  input logic [2:0] bar_reg
);
  logic pat_now, ycc_now;
  assign pat_now = sol_in ? (mode_sel == 2'b01) : pat_en_q;
  assign ycc_now = sol_in ? fmt_ycc : fmt_q;

  AST_SOL_HIGH_DELAY: assert property (@(posedge clk) disable iff (rst) sol_in |=> sol_out); // R8
  AST_SOL_LOW_DELAY:  assert property (@(posedge clk) disable iff (rst) !sol_in |=> !sol_out); // R8
  AST_ACT_DELAY:      assert property (@(posedge clk) disable iff (rst) vid_act_in |=> vid_act_out); // R8
  AST_PASS_THROUGH:   assert property (@(posedge clk) disable iff (rst)
    !pat_now |=> (out_c0 == $past(in_c0) && out_c1 == $past(in_c1) && out_c2 == $past(in_c2))); // R1
  AST_RGB_LEVELS:     assert property (@(posedge clk) disable iff (rst)
    (pat_now && !ycc_now) |=> ((out_c0 == 8'd0 || out_c0 == 8'd255) &&
                               (out_c1 == 8'd0 || out_c1 == 8'd255) &&
                               (out_c2 == 8'd0 || out_c2 == 8'd255))); // R4
  AST_YCC_RANGE:      assert property (@(posedge clk) disable iff (rst)
    (pat_now && ycc_now) |=> (out_c0 >= 8'd16 && out_c0 <= 8'd235 &&
                              out_c1 >= 8'd16 && out_c1 <= 8'd240 &&
                              out_c2 >= 8'd16 && out_c2 <= 8'd240)); // R5
  AST_BLANK_BLACK:    assert property (@(posedge clk) disable iff (rst)
    (pat_now && !vid_act_in && !ycc_now) |=> (out_c0 == 8'd0 && out_c1 == 8'd0 && out_c2 == 8'd0)); // R9
  AST_BAR_FORWARD:    assert property (@(posedge clk) disable iff (rst)
    !sol_in |=> bar_reg >= $past(bar_reg)); // R3
  AST_RESET_STROBES:  assert property (@(posedge clk) rst |=> (!vid_act_out && !sol_out)); // R10
endmodule

bind cbar_gen cbar_gen_chk u_chk (
  .clk(clk), .rst(rst), .mode_sel(mode_sel), .fmt_ycc(fmt_ycc),
  .vid_act_in(vid_act_in), .sol_in(sol_in),
  .in_c0(in_c0), .in_c1(in_c1), .in_c2(in_c2),
  .vid_act_out(vid_act_out), .sol_out(sol_out),
  .out_c0(out_c0), .out_c1(out_c1), .out_c2(out_c2),
  .pat_en_q(pat_en_q), .fmt_q(fmt_q), .bar_reg(bar_reg)
);

// File: tb/cbar_gen_test.sv
module cbar_gen_test;
  localparam int WIDTH_W = 12;

  typedef struct {
    logic [7:0] c0, c1, c2;
    logic       act, sol;
    string      req;
  } exp_t;

  logic               clk = 1'b0;
  logic               rst = 1'b1;
  logic [1:0]         mode_sel = 2'b00;
  logic               fmt_ycc = 1'b0;
  logic [WIDTH_W-1:0] line_width = '0;
  logic               vid_act_in = 1'b0, sol_in = 1'b0;
  logic [7:0]         in_c0 = '0, in_c1 = '0, in_c2 = '0;
  logic               vid_act_out, sol_out;
  logic [7:0]         out_c0, out_c1, out_c2;

  int checks = 0, failures = 0;
  bit done = 1'b0;
  exp_t q[$];

  // bench model state
  logic [1:0] m_mode = 2'b00;
  logic       m_fmt = 1'b0;
  int         m_bw = 0, m_cnt = 0;

  // stimulus-side configuration (applied by step at the negedge)
  logic [1:0] cfg_mode = 2'b00;
  logic       cfg_fmt = 1'b0;
  int         cfg_width = 64;

  byte unsigned ytab[8]  = '{235, 210, 170, 145, 106, 81, 41, 16};
  byte unsigned cbtab[8] = '{128, 16, 166, 54, 202, 90, 240, 128};
  byte unsigned crtab[8] = '{128, 146, 16, 34, 222, 240, 110, 128};
  byte unsigned rtab[8]  = '{255, 255, 0, 0, 255, 255, 0, 0};
  byte unsigned gtab[8]  = '{255, 255, 255, 255, 0, 0, 0, 0};
  byte unsigned btab[8]  = '{255, 0, 255, 0, 255, 0, 255, 0};

  cbar_gen #(.WIDTH_W(WIDTH_W)) uut (
    .clk(clk), .rst(rst), .mode_sel(mode_sel), .fmt_ycc(fmt_ycc),
    .line_width(line_width), .vid_act_in(vid_act_in), .sol_in(sol_in),
    .in_c0(in_c0), .in_c1(in_c1), .in_c2(in_c2),
    .vid_act_out(vid_act_out), .sol_out(sol_out),
    .out_c0(out_c0), .out_c1(out_c1), .out_c2(out_c2)
  );

  always #4 clk = ~clk;

  // one cycle of stimulus plus the expected result it must produce
  task automatic step(input bit r, input bit s, input bit a, input logic [7:0] p0,
                      input logic [7:0] p1, input logic [7:0] p2, input string req);
    exp_t e;
    int bar;
    @(negedge clk);
    rst = r; sol_in = s; vid_act_in = a;
    in_c0 = p0; in_c1 = p1; in_c2 = p2;
    mode_sel = cfg_mode; fmt_ycc = cfg_fmt; line_width = WIDTH_W'(cfg_width);
    e.req = req;
    if (r) begin
      e.act = 0; e.sol = 0;
      e.c0 = cfg_fmt ? 8'd16 : 8'd0;
      e.c1 = cfg_fmt ? 8'd128 : 8'd0;
      e.c2 = cfg_fmt ? 8'd128 : 8'd0;
      m_mode = 2'b00; m_cnt = 0; m_bw = 0;
    end else begin
      e.act = a; e.sol = s;
      if (s) begin
        m_mode = cfg_mode; m_fmt = cfg_fmt; m_bw = cfg_width / 8; m_cnt = 0;
      end
      if (m_mode != 2'b01) begin
        e.c0 = p0; e.c1 = p1; e.c2 = p2;
      end else begin
        bar = 7;
        if (!a) bar = 7;
        else if (m_bw == 0) bar = 0;
        else if (m_cnt / m_bw < 7) bar = m_cnt / m_bw;
        e.c0 = m_fmt ? ytab[bar]  : rtab[bar];
        e.c1 = m_fmt ? cbtab[bar] : gtab[bar];
        e.c2 = m_fmt ? crtab[bar] : btab[bar];
      end
      if (a) m_cnt++;
    end
    q.push_back(e);
  endtask

  // monitor: output registered at this edge belongs to the oldest item
  always @(posedge clk) begin
    #1;
    if (q.size() > 0) begin
      exp_t e;
      e = q.pop_front();
      checks++;
      if (out_c0 !== e.c0 || out_c1 !== e.c1 || out_c2 !== e.c2 ||
          vid_act_out !== e.act || sol_out !== e.sol) begin
        failures++;
        $display("FAIL %s actual=%0d/%0d/%0d act=%0b sol=%0b expected=%0d/%0d/%0d act=%0b sol=%0b",
                 e.req, out_c0, out_c1, out_c2, vid_act_out, sol_out,
                 e.c0, e.c1, e.c2, e.act, e.sol);
      end
    end
  end

  // one line: strobe, pixels (optional gap every gap_n pixels), blanking.
  // chg_at >= 0 scrambles mode/format/width from that pixel on (must be ignored).
  task automatic run_line(input logic [1:0] md, input logic fm, input int w,
                          input int gap_n, input int chg_at, input bit sol_on_px,
                          input string req);
    cfg_mode = md; cfg_fmt = fm; cfg_width = w;
    if (!sol_on_px) step(0, 1, 0, 8'h11, 8'h22, 8'h33, req);
    for (int k = 0; k < w; k++) begin
      if (k == chg_at) begin
        cfg_mode = ~md; cfg_fmt = ~fm; cfg_width = 16;
      end
      if (gap_n > 0 && k > 0 && (k % gap_n) == 0)
        step(0, 0, 0, 8'(k + 5), 8'(k * 3), 8'(255 - k), req);
      step(0, sol_on_px && k == 0, 1, 8'(k * 7 + 3), 8'(k + 40), 8'(200 - k), req);
    end
    step(0, 0, 0, 8'h5A, 8'hA5, 8'h3C, req);
    step(0, 0, 0, 8'h01, 8'h02, 8'h03, req);
  endtask

  initial begin
    // R10: reset in YCbCr then RGB format
    cfg_fmt = 1'b1;
    step(1, 0, 0, 8'h77, 8'h88, 8'h99, "R10");
    step(1, 1, 1, 8'h77, 8'h88, 8'h99, "R10");
    cfg_fmt = 1'b0;
    step(1, 0, 1, 8'h77, 8'h88, 8'h99, "R10");
    // R10: after reset pattern is off until a strobe, even with mode 01 applied
    cfg_mode = 2'b01;
    step(0, 0, 1, 8'h12, 8'h34, 8'h56, "R10");
    step(0, 0, 1, 8'h65, 8'h43, 8'h21, "R10");
    // R3 R4 R6 R9: RGB bars, width a multiple of eight
    run_line(2'b01, 1'b0, 64, 0, -1, 0, "R4");
    // R5: YCbCr bars
    run_line(2'b01, 1'b1, 64, 0, -1, 0, "R5");
    // R6: width 70 leaves a remainder for the last bar
    run_line(2'b01, 1'b1, 70, 0, -1, 0, "R6");
    run_line(2'b01, 1'b0, 83, 0, -1, 0, "R6");
    // R7: gaps in active video, strobe coinciding with the first pixel
    run_line(2'b01, 1'b0, 40, 3, -1, 0, "R7");
    run_line(2'b01, 1'b1, 48, 0, -1, 1, "R7");
    // R2: settings changed mid-line are ignored
    run_line(2'b01, 1'b1, 64, 0, 20, 0, "R2");
    run_line(2'b00, 1'b0, 32, 0, 10, 0, "R2");
    // R1: other mode codes pass the input through
    run_line(2'b00, 1'b1, 24, 2, -1, 0, "R1");
    run_line(2'b10, 1'b0, 24, 0, -1, 0, "R1");
    run_line(2'b11, 1'b1, 24, 0, -1, 0, "R1");
    // R6: very short line, bar width zero stays on bar 0
    run_line(2'b01, 1'b0, 6, 0, -1, 0, "R6");
    // R10: reset in the middle of a pattern line
    cfg_mode = 2'b01; cfg_fmt = 1'b1; cfg_width = 64;
    step(0, 1, 1, 8'h00, 8'h00, 8'h00, "R8");
    for (int k = 0; k < 10; k++) step(0, 0, 1, 8'(k), 8'(k), 8'(k), "R3");
    step(1, 0, 1, 8'h44, 8'h44, 8'h44, "R10");
    step(0, 0, 1, 8'h9A, 8'hBC, 8'hDE, "R10");
    run_line(2'b01, 1'b1, 16, 0, -1, 0, "R3");
    @(negedge clk);
    @(negedge clk);
    done = 1'b1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(8 * 100000);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule